// File: doc/BRIEF.md
# Dual-Clock Watchdog Timer

This block is a watchdog timer that counts on its own dedicated clock, so it keeps running while the processor sleeps with its system clock stopped. A base counter of configurable width advances on ticks from a 7-bit prescaler. The division ratio of the prescaler is chosen at run time with a 3-bit select. Software restarts the count with a one-cycle kick pulse in the system domain. That pulse crosses into the watchdog domain and clears both the prescaler and the counter.

What a timeout does depends on the sleep state seen in the watchdog domain. While the processor is awake, the timeout raises a reset request in the system domain. The request stays high until the system acknowledges it. While the processor is asleep, the timeout instead raises a wake output straight from the watchdog domain, and this output works with the system clock gated. The processor then continues, and two status flags record that the last event was a watchdog timeout and whether it happened during sleep. Entering sleep clears the count, so a sleeping processor always gets a full period before it is woken.

Top module: `wdog_top`

## Requirements
- R1: While `rst_n_i` is low, and right after it rises, `rst_req_o`, `wake_o`, `wd_flag_o` and `slp_flag_o` are all 0.
- R2: The interval between consecutive timeouts is exactly 2^(CNT_W + `ps_sel_i`) watchdog clock cycles, where `ps_sel_i` ranges over 0..7. After a timeout the counter wraps and keeps counting without any software action.
- R3: A timeout while awake sets `rst_req_o`, which stays 1 until a cycle with `ack_i` = 1; `rst_req_o` is 0 in the system cycle after that acknowledge.
- R4: A one-cycle `kick_i` pulse restarts the count, so the next timeout comes between 2^(CNT_W+sel) and 2^(CNT_W+sel)+5 watchdog cycles after the kick. Kicks spaced less than one period apart prevent any timeout.
- R5: A timeout while `sleep_i` = 1 sets `wake_o` even when the system clock is stopped, and it does not set `rst_req_o`. `wake_o` returns to 0 within 5 watchdog cycles after `sleep_i` falls.
- R6: A rise of `sleep_i` clears the count, so the first wake comes between 2^(CNT_W+sel) and 2^(CNT_W+sel)+4 watchdog cycles after `sleep_i` rises.
- R7: An awake timeout leaves `wd_flag_o`=1 and `slp_flag_o`=0. A sleep timeout leaves both at 1 once the system clock runs. A `kick_i` pulse clears both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys_i | input | 1 | System clock (may be gated during sleep) |
| clk_wd_i | input | 1 | Free-running watchdog clock |
| rst_n_i | input | 1 | Asynchronous active-low reset for both domains |
| kick_i | input | 1 | One-cycle restart command, system domain |
| ack_i | input | 1 | Acknowledge of the reset request, system domain |
| sleep_i | input | 1 | Processor is asleep (level) |
| ps_sel_i | input | 3 | Prescale select: period multiplied by 2^ps_sel_i |
| rst_req_o | output | 1 | Watchdog reset request, held until acknowledged |
| wake_o | output | 1 | Wake request from the watchdog domain |
| wd_flag_o | output | 1 | Last event was a watchdog timeout |
| slp_flag_o | output | 1 | That timeout occurred during sleep |

## Verification
The bench measures the exact spacing between successive reset requests at two prescale settings. A prescaler that divides by the wrong power of two, or a counter that stalls after a timeout, would shift that spacing. The bench puts the processor to sleep late in a period and stops the system clock. A design that did not clear on sleep entry would wake far too early, and one that routed the timeout through the system domain would never wake. It also kicks steadily across several periods and then stops. A lost kick crossing would produce a spurious reset request or a late one. The held request and the status flags are checked before and after acknowledge and kick, to catch a request that drops early or a flag set on the wrong path.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned PRE_W = 7;
  localparam int unsigned SEL_W = 3;

  // toggle pair carried from the watchdog domain to the system domain
  typedef struct packed {
    logic rst_t;
    logic wake_t;
  } evt_tog_t;
endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh;
  logic [STAGES-1:0] sh_nx;

  always_comb sh_nx = {sh[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh <= '0;
    else         sh <= sh_nx;
  end

  assign rst_n_o = sh[STAGES-1];
endmodule

// File: rtl/wdog_sync.sv
module wdog_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES*W-1:0] sh;
  logic [STAGES*W-1:0] sh_nx;

  always_comb sh_nx = {sh[(STAGES-1)*W-1:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= sh_nx;
  end

  assign q = sh[STAGES*W-1 -: W];
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kick_tog_i,
  input  logic             sleep_i,
  input  logic [SEL_W-1:0] sel_i,
  output evt_tog_t         tog_o,
  output logic             wake_o
);
  logic [1:0]       sy;
  logic             ks, ss, kq, sq;
  logic [PRE_W-1:0] pre, pre_nx, mask;
  logic [CNT_W-1:0] cnt, cnt_nx;
  evt_tog_t         tog_nx;
  logic             wake_nx, clr, tick, tmo;

  wdog_sync #(.W(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({kick_tog_i, sleep_i}), .q(sy)
  );
  assign ks = sy[1];
  assign ss = sy[0];

  always_comb begin
    for (int i = 0; i < int'(PRE_W); i++) mask[i] = (i < int'(sel_i));
    clr  = (ks ^ kq) | (ss & ~sq);
    tick = &(pre | ~mask);
    tmo  = tick & (&cnt) & ~clr;
    pre_nx = clr ? '0 : pre + PRE_W'(1);
    cnt_nx = clr ? '0 : (tick ? cnt + CNT_W'(1) : cnt);
    tog_nx.rst_t  = tog_o.rst_t  ^ (tmo & ~ss);
    tog_nx.wake_t = tog_o.wake_t ^ (tmo & ss);
    wake_nx = ss & (wake_o | tmo);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kq <= 1'b0; sq <= 1'b0; pre <= '0; cnt <= '0;
      tog_o <= '0; wake_o <= 1'b0;
    end else begin
      kq <= ks; sq <= ss; pre <= pre_nx; cnt <= cnt_nx;
      tog_o <= tog_nx; wake_o <= wake_nx;
    end
  end
endmodule

// File: rtl/wdog_sysif.sv
module wdog_sysif
  import wdog_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     kick_i,
  input  logic     ack_i,
  input  evt_tog_t tog_i,
  output logic     kick_tog_o,
  output logic     rst_req_o,
  output logic     wd_flag_o,
  output logic     slp_flag_o
);
  logic [1:0] sy;
  evt_tog_t   ts, tq;
  logic       er, ew;
  logic       kt_nx, req_nx, wd_nx, sf_nx;

  wdog_sync #(.W(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(tog_i), .q(sy)
  );
  assign ts = evt_tog_t'(sy);

  always_comb begin
    er     = ts.rst_t ^ tq.rst_t;
    ew     = ts.wake_t ^ tq.wake_t;
    kt_nx  = kick_tog_o ^ kick_i;
    req_nx = er | (rst_req_o & ~ack_i);
    wd_nx  = wd_flag_o;
    sf_nx  = slp_flag_o;
    if (er | ew) begin
      wd_nx = 1'b1;
      sf_nx = ew & ~er;
    end else if (kick_i) begin
      wd_nx = 1'b0;
      sf_nx = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tq <= '0; kick_tog_o <= 1'b0; rst_req_o <= 1'b0;
      wd_flag_o <= 1'b0; slp_flag_o <= 1'b0;
    end else begin
      tq <= ts; kick_tog_o <= kt_nx; rst_req_o <= req_nx;
      wd_flag_o <= wd_nx; slp_flag_o <= sf_nx;
    end
  end
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_sys_i,
  input  logic             clk_wd_i,
  input  logic             rst_n_i,
  input  logic             kick_i,
  input  logic             ack_i,
  input  logic             sleep_i,
  input  logic [SEL_W-1:0] ps_sel_i,
  output logic             rst_req_o,
  output logic             wake_o,
  output logic             wd_flag_o,
  output logic             slp_flag_o
);
  logic     sys_rst_n, wd_rst_n, kick_tog;
  evt_tog_t tog;

  wdog_rst_sync #(.STAGES(2)) u_rs_sys (
    .clk(clk_sys_i), .arst_n(rst_n_i), .rst_n_o(sys_rst_n)
  );
  wdog_rst_sync #(.STAGES(2)) u_rs_wd (
    .clk(clk_wd_i), .arst_n(rst_n_i), .rst_n_o(wd_rst_n)
  );

  wdog_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk_wd_i), .rst_n(wd_rst_n), .kick_tog_i(kick_tog),
    .sleep_i(sleep_i), .sel_i(ps_sel_i), .tog_o(tog), .wake_o(wake_o)
  );

  wdog_sysif u_sysif (
    .clk(clk_sys_i), .rst_n(sys_rst_n), .kick_i(kick_i), .ack_i(ack_i),
    .tog_i(tog), .kick_tog_o(kick_tog), .rst_req_o(rst_req_o),
    .wd_flag_o(wd_flag_o), .slp_flag_o(slp_flag_o)
  );
endmodule

// File: rtl/wdog_top_chk.sv
module wdog_top_chk (
  input logic clk_sys,
  input logic clk_wd,
  input logic rst_n,
  input logic ack_i,
  input logic sleep_i,
  input logic rst_req_o,
  input logic wake_o,
  input logic wd_flag_o,
  input logic slp_flag_o
);
  // R3
  req_held_chk: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (rst_req_o && !ack_i) |=> rst_req_o);

  // R5
  wake_asleep_chk: assert property (@(posedge clk_wd) disable iff (!rst_n)
    $rose(wake_o) |-> sleep_i);

  // R7
  req_flags_chk: assert property (@(posedge clk_sys) disable iff (!rst_n)
    $rose(rst_req_o) |-> (wd_flag_o && !slp_flag_o));

  // R7
  slp_implies_wd_chk: assert property (@(posedge clk_sys) disable iff (!rst_n)
    slp_flag_o |-> wd_flag_o);
endmodule

bind wdog_top wdog_top_chk u_chk (
  .clk_sys(clk_sys_i), .clk_wd(clk_wd_i), .rst_n(rst_n_i), .ack_i(ack_i),
  .sleep_i(sleep_i), .rst_req_o(rst_req_o), .wake_o(wake_o),
  .wd_flag_o(wd_flag_o), .slp_flag_o(slp_flag_o)
);

// File: tb/sim_wdog_top.sv
`timescale 1ns/1ps
module sim_wdog_top;
  localparam int CW = 6;

  logic clk_raw = 1'b0;
  logic gate_n  = 1'b1;
  logic clk_wd  = 1'b0;
  logic clk_sys;
  logic rst_n, kick, ack, sleep;
  logic [2:0] sel;
  logic rst_req, wake, wd_flag, slp_flag;
  int   nchk = 0, nerr = 0, wcnt = 0;

  assign clk_sys = clk_raw & gate_n;

  always #4 clk_raw = ~clk_raw;
  initial begin
    #6;
    forever #25 clk_wd = ~clk_wd;
  end
  always @(posedge clk_wd) wcnt <= wcnt + 1;

  wdog_top #(.CNT_W(CW)) u0 (
    .clk_sys_i(clk_sys), .clk_wd_i(clk_wd), .rst_n_i(rst_n),
    .kick_i(kick), .ack_i(ack), .sleep_i(sleep), .ps_sel_i(sel),
    .rst_req_o(rst_req), .wake_o(wake), .wd_flag_o(wd_flag),
    .slp_flag_o(slp_flag)
  );

  task automatic chk_eq(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
    nchk++;
    if (act < lo || act > hi) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic sys_wait(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_raw);
  endtask

  task automatic pulse_kick();
    kick = 1'b1; @(negedge clk_raw); kick = 1'b0;
  endtask

  task automatic pulse_ack();
    ack = 1'b1; @(negedge clk_raw); ack = 1'b0;
  endtask

  task automatic wait_req(output int w);
    do @(negedge clk_raw); while (!rst_req);
    w = wcnt;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; kick = 1'b0; ack = 1'b0; sleep = 1'b0; sel = 3'd0;
    sys_wait(10);
    chk_eq("R1 rst_req in reset", int'(rst_req), 0);
    chk_eq("R1 wake in reset", int'(wake), 0);
    rst_n = 1'b1;
    sys_wait(3);
    chk_eq("R1 wd_flag after reset", int'(wd_flag), 0);
    chk_eq("R1 slp_flag after reset", int'(slp_flag), 0);
  endtask

  task automatic t_period(input int s);
    int w1, w2, w3, p;
    p = (1 << (CW + s));
    sel = 3'(s);
    pulse_kick();
    sys_wait(40);
    pulse_ack();
    wait_req(w1);
    sys_wait(5);
    chk_eq("R3 request held before ack", int'(rst_req), 1);
    chk_eq("R7 wd_flag on awake timeout", int'(wd_flag), 1);
    chk_eq("R7 slp_flag on awake timeout", int'(slp_flag), 0);
    pulse_ack();
    chk_eq("R3 request cleared by ack", int'(rst_req), 0);
    wait_req(w2);
    pulse_ack();
    wait_req(w3);
    pulse_ack();
    chk_eq("R2 period first", w2 - w1, p);
    chk_eq("R2 period second", w3 - w2, p);
    pulse_kick();
    chk_eq("R7 kick clears wd_flag", int'(wd_flag), 0);
  endtask

  task automatic t_kick();
    int seen = 0, wk, wr;
    sel = 3'd0;
    pulse_kick();
    sys_wait(40);
    pulse_ack();
    for (int k = 0; k < 20; k++) begin
      for (int c = 0; c < 160; c++) begin
        @(negedge clk_raw);
        if (rst_req) seen = 1;
      end
      pulse_kick();
    end
    wk = wcnt;
    chk_eq("R4 steady kicks prevent timeout", seen, 0);
    wait_req(wr);
    chk_rng("R4 restart after kick", wr - wk, (1 << CW), (1 << CW) + 5);
    pulse_ack();
  endtask

  task automatic t_sleep();
    int ws, ww;
    sel = 3'd0;
    pulse_kick();
    sys_wait(300);
    sleep = 1'b1;
    ws = wcnt;
    gate_n = 1'b0;
    do @(negedge clk_wd); while (!wake);
    ww = wcnt;
    chk_rng("R6 sleep entry clears count", ww - ws, (1 << CW), (1 << CW) + 4);
    chk_eq("R5 wake with system clock stopped", int'(wake), 1);
    chk_eq("R5 no reset request in sleep", int'(rst_req), 0);
    @(negedge clk_raw);
    gate_n = 1'b1;
    sys_wait(6);
    chk_eq("R7 wd_flag on sleep timeout", int'(wd_flag), 1);
    chk_eq("R7 slp_flag on sleep timeout", int'(slp_flag), 1);
    chk_eq("R5 no reset request after wake", int'(rst_req), 0);
    sleep = 1'b0;
    for (int i = 0; i < 5; i++) @(negedge clk_wd);
    chk_eq("R5 wake clears after sleep ends", int'(wake), 0);
  endtask

  initial begin
    t_reset();
    t_period(0);
    t_period(3);
    t_kick();
    t_sleep();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #1000000;
    nchk++;
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule